// File: doc/BRIEF.md
# Justifying Clock-Crossing Payload Mapper

This block is a dual-clock word buffer between a constant-bit-rate payload source and a frame formatter built on rows of fixed length. Payload words enter in the write clock domain and leave in the read clock domain. The formatter pulls one word for each payload slot it fills. Each pointer crosses into the other domain as Gray code through a two-stage synchronizer. The fill level is then worked out on the side that reads it.

A mode input turns on asynchronous mapping. With the mode on, the read side takes a snapshot of the buffer fill on each row-start strobe and compares it with two fixed thresholds. The high threshold is three quarters of the depth and the low one is one quarter. When the buffer is too full, a negative justification pulse tells the formatter to take one extra word in that row. When it is too empty, a positive justification pulse tells the formatter to skip one payload slot. In both cases the pulse is one read-clock cycle wide and comes one cycle after the strobe. After reset, nothing is handed out until the fill first reaches half the depth.

Both data edges use valid/ready. A word moves on a rising clock edge where valid and ready are both high. The write side lowers `in_ready` while the buffer holds its full depth. The source must then hold `in_data` and `in_valid` until ready returns. The read side raises `out_valid` only after the start-up fill has been reached and while at least one word is held. `out_data` is the oldest word and stays stable until it is taken.

Top module: `rate_just_mapper`

## Requirements
- R1: During and straight after reset, `out_valid`, `just_pos` and `just_neg` are low and `in_ready` is high.
- R2: `in_ready` is low once 32 words are held and not yet taken; a write offered while `in_ready` is low is not stored.
- R3: After reset, `out_valid` stays low until the fill has reached 16 words; from then on it is high whenever at least one word is held.
- R4: Words leave in the order they were written, with their values unchanged.
- R5: With `async_en` low, `just_pos` and `just_neg` never rise.
- R6: With `async_en` high and the start-up fill reached, a `row_start` cycle in which the fill is above 24 words makes `just_neg` high for exactly the next read-clock cycle.
- R7: With `async_en` high and the start-up fill reached, a `row_start` cycle in which the fill is below 8 words makes `just_pos` high for exactly the next read-clock cycle.
- R8: A fill from 8 to 24 words inclusive at `row_start` requests no justification.
- R9: A justification pulse only follows a `row_start` cycle. At most one pulse is issued per row, and `just_pos` and `just_neg` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Write-domain clock |
| in_rst_n | input | 1 | Write-domain asynchronous reset, active low |
| in_valid | input | 1 | Source offers a word |
| in_data | input | 16 | Payload word |
| in_ready | output | 1 | Buffer can take a word |
| out_clk | input | 1 | Read-domain clock |
| out_rst_n | input | 1 | Read-domain asynchronous reset, active low |
| async_en | input | 1 | Enables asynchronous mapping (justification) |
| row_start | input | 1 | One-cycle strobe at the start of each frame row |
| out_ready | input | 1 | Formatter takes a word in this cycle |
| out_valid | output | 1 | A word is available |
| out_data | output | 16 | Oldest held word |
| just_pos | output | 1 | Skip one payload slot in this row |
| just_neg | output | 1 | Take one extra word in this row |

## Verification
A wrong pointer or a corrupted synchronizer stage shows up as a wrong fill level. The justification outputs report that fill in the cycle after the next `row_start`. So a fill held at 7, 8, 24 or 25 words, and at the empty and full extremes, tells at once whether the thresholds sit on the right side of the boundary. A lost or duplicated word shows up on `out_data` on the very next read, as a value out of sequence. A start-up gate or full flag that is off by one moves the edge of `out_valid` or `in_ready` by one word, and that is seen a few cycles after the synchronizer settles.

// File: rtl/jm_pkg.sv
package jm_pkg;
  // Decision taken on a row boundary
  typedef enum logic [1:0] {
    JDEC_NONE = 2'b00,
    JDEC_POS  = 2'b01,
    JDEC_NEG  = 2'b10
  } jdec_e;
endpackage

// File: rtl/jm_gray_sync.sv
module jm_gray_sync #(
  parameter int W = 6
) (
  input  logic         dst_clk,
  input  logic         dst_rst_n,
  input  logic [W-1:0] src_gray,
  output logic [W-1:0] dst_bin
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge dst_clk or negedge dst_rst_n) begin
    if (!dst_rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= src_gray;
      stage2 <= stage1;
    end
  end

  always_comb begin
    dst_bin[W-1] = stage2[W-1];
    for (int i = W - 2; i >= 0; i--) begin
      dst_bin[i] = dst_bin[i+1] ^ stage2[i];
    end
  end
endmodule

// File: rtl/jm_store.sv
module jm_store #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          wr_clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/jm_wr_side.sv
module jm_wr_side #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [AW:0]   rd_ptr_sync,
  output logic          in_ready,
  output logic          we,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wr_gray
);
  localparam logic [AW:0] DEPTH = (AW+1)'(1 << AW);
  logic [AW:0] wr_ptr, wr_ptr_nxt, held;

  assign held       = wr_ptr - rd_ptr_sync;
  assign in_ready   = (held != DEPTH);
  assign we         = in_valid && in_ready;
  assign wr_ptr_nxt = wr_ptr + (AW+1)'(we);
  assign waddr      = wr_ptr[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      wr_gray <= '0;
    end else begin
      wr_ptr  <= wr_ptr_nxt;
      wr_gray <= wr_ptr_nxt ^ (wr_ptr_nxt >> 1);
    end
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(wr_ptr));
endmodule

// File: rtl/jm_rd_side.sv
module jm_rd_side #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          async_en,
  input  logic          row_start,
  input  logic          out_ready,
  input  logic [AW:0]   wr_ptr_sync,
  output logic          out_valid,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rd_gray,
  output logic          just_pos,
  output logic          just_neg
);
  import jm_pkg::*;
  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] HI    = (AW+1)'(DEPTH * 3 / 4);
  localparam logic [AW:0] LO    = (AW+1)'(DEPTH / 4);
  localparam logic [AW:0] MID   = (AW+1)'(DEPTH / 2);

  logic [AW:0] rd_ptr, rd_ptr_nxt, fill;
  logic        started, take;
  jdec_e       dec;

  assign fill       = wr_ptr_sync - rd_ptr;
  assign out_valid  = started && (fill != '0);
  assign take       = out_valid && out_ready;
  assign rd_ptr_nxt = rd_ptr + (AW+1)'(take);
  assign raddr      = rd_ptr[AW-1:0];

  always_comb begin
    dec = JDEC_NONE;
    if (row_start && async_en && started) begin
      if (fill > HI)      dec = JDEC_NEG;
      else if (fill < LO) dec = JDEC_POS;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr   <= '0;
      rd_gray  <= '0;
      started  <= 1'b0;
      just_pos <= 1'b0;
      just_neg <= 1'b0;
    end else begin
      rd_ptr   <= rd_ptr_nxt;
      rd_gray  <= rd_ptr_nxt ^ (rd_ptr_nxt >> 1);
      if (fill >= MID) started <= 1'b1;
      just_pos <= (dec == JDEC_POS);
      just_neg <= (dec == JDEC_NEG);
    end
  end

  // R9
  just_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(just_pos && just_neg));
  // R9
  just_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (just_pos || just_neg) |-> $past(row_start));
  // R5
  just_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (just_pos || just_neg) |-> $past(async_en));
  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !started |-> !out_valid);
  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (rd_ptr == $past(rd_ptr) + 1'b1));
endmodule

// File: rtl/rate_just_mapper.sv
module rate_just_mapper #(
  parameter int DW = 16,
  parameter int AW = 5
) (
  input  logic          in_clk,
  input  logic          in_rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          out_clk,
  input  logic          out_rst_n,
  input  logic          async_en,
  input  logic          row_start,
  input  logic          out_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic          just_pos,
  output logic          just_neg
);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_gray, rd_gray, wr_ptr_sync, rd_ptr_sync;
  logic [AW-1:0] waddr, raddr;
  logic          we;

  jm_wr_side #(.AW(AW)) u_wr (
    .clk(in_clk), .rst_n(in_rst_n), .in_valid(in_valid),
    .rd_ptr_sync(rd_ptr_sync), .in_ready(in_ready), .we(we),
    .waddr(waddr), .wr_gray(wr_gray)
  );

  jm_gray_sync #(.W(PW)) u_sync_w2r (
    .dst_clk(out_clk), .dst_rst_n(out_rst_n),
    .src_gray(wr_gray), .dst_bin(wr_ptr_sync)
  );

  jm_gray_sync #(.W(PW)) u_sync_r2w (
    .dst_clk(in_clk), .dst_rst_n(in_rst_n),
    .src_gray(rd_gray), .dst_bin(rd_ptr_sync)
  );

  jm_store #(.DW(DW), .AW(AW)) u_store (
    .wr_clk(in_clk), .we(we), .waddr(waddr), .wdata(in_data),
    .raddr(raddr), .rdata(out_data)
  );

  jm_rd_side #(.AW(AW)) u_rd (
    .clk(out_clk), .rst_n(out_rst_n), .async_en(async_en),
    .row_start(row_start), .out_ready(out_ready),
    .wr_ptr_sync(wr_ptr_sync), .out_valid(out_valid), .raddr(raddr),
    .rd_gray(rd_gray), .just_pos(just_pos), .just_neg(just_neg)
  );
endmodule

// File: tb/rate_just_mapper_tb.sv
module rate_just_mapper_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, async_en, row_start, out_ready;
  logic [15:0] in_data;
  logic        in_ready, out_valid, just_pos, just_neg;
  logic [15:0] out_data;
  int nchk = 0, nfail = 0;
  int wseq = 0, rseq = 0;

  always #5 clk = ~clk;

  rate_just_mapper u_dut (
    .in_clk(clk), .in_rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_clk(clk), .out_rst_n(rst_n),
    .async_en(async_en), .row_start(row_start), .out_ready(out_ready),
    .out_valid(out_valid), .out_data(out_data),
    .just_pos(just_pos), .just_neg(just_neg)
  );

  // fields: fill[8:3], async_en[2], expect pos[1], expect neg[0]
  localparam logic [8:0] VECS [12] = '{
    {6'd16, 1'b1, 1'b0, 1'b0}, {6'd8,  1'b1, 1'b0, 1'b0},
    {6'd7,  1'b1, 1'b1, 1'b0}, {6'd24, 1'b1, 1'b0, 1'b0},
    {6'd25, 1'b1, 1'b0, 1'b1}, {6'd32, 1'b1, 1'b0, 1'b1},
    {6'd0,  1'b1, 1'b1, 1'b0}, {6'd3,  1'b1, 1'b1, 1'b0},
    {6'd30, 1'b0, 1'b0, 1'b0}, {6'd2,  1'b0, 1'b0, 1'b0},
    {6'd20, 1'b1, 1'b0, 1'b0}, {6'd28, 1'b1, 1'b0, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0;
    row_start = 1'b0; out_ready = 1'b0;
    wseq = 0; rseq = 0;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic put(input int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = 16'(16'hA500 + wseq);
      @(negedge clk);
      wseq++;
    end
    in_valid = 1'b0;
  endtask

  task automatic take(input int n);
    for (int i = 0; i < n; i++) begin
      while (!out_valid) @(negedge clk);
      check("R4 data order", 32'(out_data), 32'(16'hA500 + rseq));
      rseq++;
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic strobe_and_check(input logic ep, input logic en, input string req);
    row_start = 1'b1;
    @(negedge clk);
    row_start = 1'b0;
    check(req, {30'd0, just_pos, just_neg}, {30'd0, ep, en});
    @(negedge clk);
    check("R9 one-cycle pulse", {30'd0, just_pos, just_neg}, 32'd0);
  endtask

  initial begin
    #2_000_000;
    nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; async_en = 1'b0;
    do_reset();
    // R1 reset state
    check("R1 reset outputs", {28'd0, out_valid, just_pos, just_neg, in_ready}, 32'd1);

    // Table of fill levels
    for (int v = 0; v < 12; v++) begin
      int f;
      f = int'(VECS[v][8:3]);
      async_en = VECS[v][2];
      do_reset();
      if (f >= 16) put(f);
      else begin put(16); idle(6); take(16 - f); end
      idle(6);
      strobe_and_check(VECS[v][1], VECS[v][0],
        VECS[v][2] == 1'b0 ? "R5 mode off" :
        VECS[v][0] ? "R6 negative" : VECS[v][1] ? "R7 positive" : "R8 in band");
    end

    // R3 start-up hold off
    async_en = 1'b1;
    do_reset();
    put(15); idle(6);
    check("R3 held before midpoint", 32'(out_valid), 32'd0);
    put(1); idle(6);
    check("R3 released at midpoint", 32'(out_valid), 32'd1);
    take(16); idle(4);
    check("R3 empty after drain", 32'(out_valid), 32'd0);

    // R2 full
    do_reset();
    put(32); idle(6);
    check("R2 full lowers ready", 32'(in_ready), 32'd0);
    in_valid = 1'b1; in_data = 16'hDEAD;
    @(negedge clk);
    in_valid = 1'b0;
    take(32); idle(6);
    check("R2 rejected write not stored", 32'(out_valid), 32'd0);
    check("R2 ready back", 32'(in_ready), 32'd1);

    // R9 no pulse without a row strobe
    do_reset();
    put(30); idle(4);
    for (int i = 0; i < 10; i++) begin
      check("R9 no strobe no pulse", {30'd0, just_pos, just_neg}, 32'd0);
      @(negedge clk);
    end
    strobe_and_check(1'b0, 1'b1, "R6 after quiet rows");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule